// File: doc/BRIEF.md
# Fixed-Frequency Duty-Controlled PWM Generator

This block turns an 8-bit duty setting into a rectangular wave whose frequency never changes. A free-running up-counter divides the input clock by 256, so a 25.6 MHz clock gives a 100 kHz output. The output comes from a set/clear flip-flop rather than a magnitude comparator. The counter wrapping back to zero sets it. The counter stepping onto the duty value clears it. The high time per period is therefore the duty value counted in clock steps, and the duty ratio is that value over 256.

The duty input is a plain level, for example the position of a rotary control decoded elsewhere. It is captured only at the counter wrap, so the duty can be changed at any time without truncating or stretching the period in progress. A setting of zero holds the output low, because a clear and a set on the same edge resolve to clear. A setting of 255 gives the longest pulse, high for 255 of 256 steps. The pins are plain control pins with no handshake.

Top module: `pwm_duty_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, the output is low and the counter is zero. The first period after reset is all low, because the captured duty starts at zero.
- R2: Every period lasts 256 clocks. When the captured duty is non-zero, the output rises only on the clock edge where the counter wraps from 255 to 0.
- R3: With a captured duty N in 1..254, the output is high for exactly N clocks, while the counter is 0..N-1, and low while the counter is N..255.
- R4: With a captured duty of 0, the output stays low for the whole period, since the clear wins over the set on the wrap edge.
- R5: With a captured duty of 255, the output is high for 255 clocks and low only while the counter is 255.
- R6: The duty input is sampled only on the wrap edge. Changes during a period, including several changes, have no effect on that period. The last value present before the wrap edge governs the whole next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock, 256 times the output frequency |
| rst_n | input | 1 | Asynchronous reset, active low |
| duty_in | input | 8 | Requested high time in clock steps, 0..255 |
| pwm_out | output | 1 | PWM output, registered |

## Verification
A wrong counter phase or a lost wrap shows at the pins as a rising edge that is shifted or missing. That error appears within one period, and no more than 256 clocks. A duty register loaded at the wrong moment shows as a pulse width that follows the mid-period input instead of the previous one, visible at the first falling edge after the change. A wrong priority between set and clear shows as a one-clock glitch high in a zero-duty period, or as a stuck-high output. The bench predicts every output sample of every period from the duty sequence alone and compares clock by clock.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Action applied to the output flip-flop on an edge
  typedef enum logic [1:0] {
    FLOP_HOLD  = 2'd0,
    FLOP_SET   = 2'd1,
    FLOP_CLEAR = 2'd2
  } flop_act_t;

  // Resolve set/clear requests: clear has priority (zero duty stays low)
  function automatic flop_act_t resolve_act(input logic set_req, input logic clr_req);
    if (clr_req)      return FLOP_CLEAR;
    else if (set_req) return FLOP_SET;
    else              return FLOP_HOLD;
  endfunction

endpackage

// File: rtl/pwm_wrap_counter.sv
module pwm_wrap_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_next,
  output logic         wrap
);
  localparam logic [W-1:0] CNT_MAX = '1;

  assign cnt_next = cnt + 1'b1;
  assign wrap     = (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;
  end

  // R2: every wrap returns the counter to zero on the following edge
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

endmodule

// File: rtl/pwm_duty_latch.sv
module pwm_duty_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] duty_in,
  output logic [W-1:0] duty_q,
  output logic [W-1:0] duty_eff
);
  // Value in force for the coming counter step
  assign duty_eff = load ? duty_in : duty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    duty_q <= '0;
    else if (load) duty_q <= duty_in;
  end

  // R6: captured duty changes only across a wrap edge
  a_r6_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(duty_q));

endmodule

// File: rtl/pwm_setclr_flop.sv
module pwm_setclr_flop
  import pwm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic q
);
  flop_act_t act;

  assign act = resolve_act(set_req, clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else begin
      case (act)
        FLOP_SET:   q <= 1'b1;
        FLOP_CLEAR: q <= 1'b0;
        default:    q <= q;
      endcase
    end
  end

  // R4: a clear request always leaves the output low
  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !q);

endmodule

// File: rtl/pwm_duty_gen.sv
module pwm_duty_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] duty_in,
  output logic         pwm_out
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt;
  logic [W-1:0] cnt_next;
  logic         wrap;
  logic [W-1:0] duty_q;
  logic [W-1:0] duty_eff;
  logic         clr_req;

  pwm_wrap_counter #(.W(W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .cnt_next (cnt_next),
    .wrap     (wrap)
  );

  pwm_duty_latch #(.W(W)) u_duty (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wrap),
    .duty_in  (duty_in),
    .duty_q   (duty_q),
    .duty_eff (duty_eff)
  );

  // Clear when the counter steps into the duty value (N-1 -> N).
  // For N = 0 this coincides with the wrap edge.
  assign clr_req = (cnt_next == duty_eff);

  pwm_setclr_flop u_flop (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (wrap),
    .clr_req (clr_req),
    .q       (pwm_out)
  );

  // R1: leaving reset, output low and counter at zero
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (!pwm_out && cnt == '0));

  // R2: output rises only at the start of a period
  a_r2_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> (cnt == '0));

  // R3: output falls exactly where the counter equals the captured duty
  a_r3_fall_at_duty: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_out) |-> (cnt == duty_q));

  // R4: a zero captured duty keeps the output low
  a_r4_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_out);

  // R5: last step of every period is low, even at full duty
  a_r5_low_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |-> !pwm_out);

endmodule

// File: tb/test_pwm_duty_gen.sv
module test_pwm_duty_gen;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] duty_in = 8'd0;
  logic       pwm_out;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   drv_done = 1'b0;

  always #5 clk = ~clk;

  pwm_duty_gen #(.W(8)) i_pwm_duty_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .duty_in (duty_in),
    .pwm_out (pwm_out)
  );

  // Duty sequence, one entry per period starting with period 1
  localparam int NP = 12;
  int seq [NP] = '{64, 64, 1, 0, 255, 128, 200, 0, 0, 3, 255, 254};

  task automatic push_period(input int n, input int prev);
    for (int c = 0; c < 256; c++) begin
      exp_t e;
      e.val = (c < n);
      if (n == 0)            e.tag = "R4";
      else if (n == 255)     e.tag = "R5";
      else if (c == 0)       e.tag = "R2";
      else if (n != prev)    e.tag = "R6";
      else                   e.tag = "R3";
      exp_q.push_back(e);
    end
  endtask

  // Driver
  initial begin
    duty_in = 8'(seq[0]);
    repeat (3) @(negedge clk);
    n_cmp++;
    if (pwm_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 during reset: pwm_out=%b expected 0", pwm_out);
    end
    // Period 0: counter 1..255 sampled after release, all low (R1)
    for (int c = 1; c < 256; c++) begin
      exp_t e;
      e.val = 1'b0;
      e.tag = "R1";
      exp_q.push_back(e);
    end
    push_period(seq[0], 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (256 + 100) @(negedge clk);
    for (int i = 1; i < NP; i++) begin
      // Junk value mid-period must not affect anything (R6)
      duty_in = 8'(seq[i] ^ 8'h5A);
      repeat (28) @(negedge clk);
      duty_in = 8'(seq[i]);
      push_period(seq[i], seq[i-1]);
      repeat (228) @(negedge clk);
    end
    drv_done = 1'b1;
  end

  // Monitor / scoreboard
  initial begin
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (pwm_out !== e.val) begin
          n_bad++;
          $display("FAIL %s at %0t: pwm_out=%b expected %b", e.tag, $time, pwm_out, e.val);
        end
      end
    end
  end

  // Completion
  initial begin
    wait (drv_done && exp_q.size() == 0);
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: done=%0d expected 1", drv_done);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule